// File: doc/BRIEF.md
# Subsystem Sleep and Wakeup Clock Controller

This block decides when a peripheral subsystem may lose its clock and when it gets it back. Software arms sleep with a mode bit and then fires a one-cycle request to enter sleep. The controller waits until the subsystem's data engine reports that it is idle, then drops the clock enable that drives the subsystem's clock-gating cell. At the same time it raises a sleep flag toward the bus bridge, so the bridge can answer register accesses with an error response instead of forwarding them.

The controller runs on the ungated clock and stays alive while the subsystem sleeps. When the bridge decodes an access to the subsystem's address range, it asserts a wakeup select. The controller then turns the clock back on one cycle before it clears the sleep flag. This gives the subsystem one clocked cycle before the bridge starts forwarding traffic again. Idle is qualified: the engine must report not-busy for `IDLE_HOLD` consecutive cycles, and it must still be not-busy in the cycle of the transition.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), clk_en_o is 1 and sleep_o is 0.
- R2: A request pulse (enter_req_i=1) while sleep_en_i is 0 is ignored. The block stays clocked and does not sleep later, even when the engine goes idle.
- R3: After an accepted request (enter_req_i=1 with sleep_en_i=1), the block keeps clk_en_o=1 and sleep_o=0 for as long as busy_i stays 1.
- R4: Once armed, the block enters sleep at the first clock edge where busy_i is 0 and busy_i was also 0 at each of the previous `IDLE_HOLD` edges. Any busy cycle restarts that count. Sleep shows as clk_en_o=0 and sleep_o=1.
- R5: While sleeping, clk_en_o stays 0 and sleep_o stays 1 whatever sleep_en_i, enter_req_i and busy_i do, until wake_sel_i is 1.
- R6: wake_sel_i=1 at an edge while sleeping gives clk_en_o=1 with sleep_o=1 for one cycle, then clk_en_o=1 with sleep_o=0.
- R7: wake_sel_i=1 while armed (waiting for idle) cancels the request and returns to normal running. This holds even when idle qualification completes at the same edge.
- R8: Clearing sleep_en_i while armed cancels the request. The block returns to normal running without sleeping.
- R9: clk_en_o=0 never occurs together with sleep_o=0, and sleep_o only falls after clk_en_o has been 1 for a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_en_i | input | 1 | Software sleep permission |
| enter_req_i | input | 1 | One-cycle request to enter sleep |
| busy_i | input | 1 | Data engine is active |
| wake_sel_i | input | 1 | Bridge-decoded wakeup select |
| clk_en_o | output | 1 | Enable to the subsystem clock-gating cell |
| sleep_o | output | 1 | Subsystem is asleep; bridge should error accesses |

## Verification
The delicate coincidence is a wakeup select arriving at the same edge where idle qualification completes while the block is armed. In that case the wakeup must win, so that an access already under way is not answered with an error. The bench provokes this by first arming the block with the engine busy. It then lets the idle count run up to its saturation value, and only then applies every combination of the four inputs for a single cycle. An independent cycle model written from the requirements predicts both outputs for every combination, and any divergence is reported. The same all-combination sweep is repeated from the running, freshly armed, sleeping and waking states, and a long pseudo-random run follows.

// File: rtl/pm_sleep_pkg.sv
// Package: shared state encoding for the sleep controller.
// Assumes: two state bits are enough; the encoding is not visible at the ports.
package pm_sleep_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_ARMED = 2'd1,
        PM_SLEEP = 2'd2,
        PM_WAKE  = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pm_idle_qual.sv
// Idle qualifier: reports that the engine has been not-busy for HOLD
// consecutive clock edges. HOLD of 0 passes the live not-busy level through.
// Assumes: busy_i is synchronous to clk.
module pm_idle_qual #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic idle_ok_o
);
    generate
        if (HOLD == 0) begin : g_direct
            // No history required: idle is the current not-busy level.
            assign idle_ok_o = ~busy_i;
        end else begin : g_count
            localparam int CW = $clog2(HOLD + 1);
            localparam logic [CW-1:0] SAT = CW'(HOLD);
            logic [CW-1:0] run_q;

            // Count consecutive idle edges, saturating, restarting on busy.
            always_ff @(posedge clk) begin
                if (!rst_n)         run_q <= '0;
                else if (busy_i)    run_q <= '0;
                else if (run_q != SAT) run_q <= run_q + 1'b1;
            end

            assign idle_ok_o = (run_q == SAT);
        end
    endgenerate
endmodule

// File: rtl/pm_sleep_fsm.sv
// Sleep state machine: arms on an accepted request, sleeps when idle is
// qualified, and wakes through a one-cycle overlap state.
// Assumes: idle_ok_i is registered history and busy_i is the live level;
// wakeup has priority over sleep entry while armed.
module pm_sleep_fsm
    import pm_sleep_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_en_i,
    input  logic      enter_req_i,
    input  logic      busy_i,
    input  logic      wake_sel_i,
    input  logic      idle_ok_i,
    output pm_state_e state_o
);
    pm_state_e cur_q, nxt;

    // Next-state selection.
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PM_RUN:   if (enter_req_i && sleep_en_i) nxt = PM_ARMED;
            PM_ARMED: begin
                if (wake_sel_i || !sleep_en_i)   nxt = PM_RUN;
                else if (idle_ok_i && !busy_i)   nxt = PM_SLEEP;
            end
            PM_SLEEP: if (wake_sel_i) nxt = PM_WAKE;
            PM_WAKE:  nxt = PM_RUN;
            default:  nxt = PM_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= PM_RUN;
        else        cur_q <= nxt;
    end

    assign state_o = cur_q;
endmodule

// File: rtl/pm_sleep_ctrl.sv
// Top: clock-enable and sleep-flag controller for a gated subsystem.
// Assumes: it sits on the ungated clock; the gating cell and the register
// decode that produce sleep_en_i / enter_req_i live outside.
module pm_sleep_ctrl
    import pm_sleep_pkg::*;
#(
    parameter int IDLE_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_en_i,
    input  logic enter_req_i,
    input  logic busy_i,
    input  logic wake_sel_i,
    output logic clk_en_o,
    output logic sleep_o
);
    logic      idle_ok;
    pm_state_e state;

    pm_idle_qual #(.HOLD(IDLE_HOLD)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_i),
        .idle_ok_o (idle_ok)
    );

    pm_sleep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_en_i  (sleep_en_i),
        .enter_req_i (enter_req_i),
        .busy_i      (busy_i),
        .wake_sel_i  (wake_sel_i),
        .idle_ok_i   (idle_ok),
        .state_o     (state)
    );

    // Output decode straight from the state register (glitch-free enables).
    assign clk_en_o = (state != PM_SLEEP);
    assign sleep_o  = (state == PM_SLEEP) || (state == PM_WAKE);
endmodule

// File: rtl/pm_sleep_ctrl_chk.sv
// Checker: temporal properties of the sleep controller, bound to the top.
module pm_sleep_ctrl_chk
    import pm_sleep_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sleep_en_i,
    input logic      enter_req_i,
    input logic      busy_i,
    input logic      wake_sel_i,
    input logic      clk_en_o,
    input logic      sleep_o,
    input pm_state_e state
);
    // R2
    ignored_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_RUN && enter_req_i && !sleep_en_i) |=> (state == PM_RUN));
    // R4
    sleep_entry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> ($past(!busy_i) && $past(sleep_en_i)));
    // R5
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o && !wake_sel_i) |=> (!clk_en_o && sleep_o));
    // R6
    wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> sleep_o);
    // R6
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_o && wake_sel_i) |=> (clk_en_o && sleep_o) ##1 (clk_en_o && !sleep_o));
    // R7
    armed_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_ARMED && wake_sel_i) |=> (state == PM_RUN));
    // R9
    release_after_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> $past(clk_en_o));
endmodule

bind pm_sleep_ctrl pm_sleep_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_en_i  (sleep_en_i),
    .enter_req_i (enter_req_i),
    .busy_i      (busy_i),
    .wake_sel_i  (wake_sel_i),
    .clk_en_o    (clk_en_o),
    .sleep_o     (sleep_o),
    .state       (state)
);

// File: tb/sim_pm_sleep_ctrl.sv
`timescale 1ns/100ps
module sim_pm_sleep_ctrl;
    localparam int H = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_en = 1'b0, enter_req = 1'b0, busy = 1'b0, wake_sel = 1'b0;
    logic clk_en, sleep;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model: 0 run, 1 armed, 2 sleep, 3 waking.
    int m_st = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    pm_sleep_ctrl #(.IDLE_HOLD(H)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_en_i(sleep_en), .enter_req_i(enter_req),
        .busy_i(busy), .wake_sel_i(wake_sel), .clk_en_o(clk_en), .sleep_o(sleep)
    );

    function automatic logic [1:0] exp_out();
        // {clk_en, sleep} expected for the model state.
        case (m_st)
            0, 1: return 2'b10;
            2:    return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check(input logic [1:0] exp, input string tag);
        n_cmp++;
        if ({clk_en, sleep} !== exp) begin
            n_bad++;
            $display("FAIL %s: {clk_en,sleep} actual=%b expected=%b at %0t",
                     tag, {clk_en, sleep}, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_en = 0; enter_req = 0; busy = 0; wake_sel = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0;
    endtask

    task automatic step(input logic m, input logic e, input logic b,
                        input logic w, input string tag);
        bit ok;
        sleep_en = m; enter_req = e; busy = b; wake_sel = w;
        @(posedge clk);
        ok = (m_cnt >= H);
        case (m_st)
            0: if (e && m) m_st = 1;
            1: if (w || !m) m_st = 0; else if (ok && !b) m_st = 2;
            2: if (w) m_st = 3;
            default: m_st = 0;
        endcase
        m_cnt = b ? 0 : ((m_cnt < H) ? m_cnt + 1 : m_cnt);
        @(negedge clk);
        check(exp_out(), tag);
    endtask

    // Drive the design into a chosen starting state for the sweep.
    task automatic reach(input int s);
        do_reset();
        case (s)
            0: begin step(0,0,0,0,"R1"); step(0,0,0,0,"R1"); step(0,0,0,0,"R1"); end
            1: begin step(1,1,1,0,"R3"); end
            2: begin step(1,1,1,0,"R3"); step(1,0,0,0,"R4"); step(1,0,0,0,"R4"); end
            3: begin repeat (3) step(0,0,0,0,"R1"); step(1,1,0,0,"R4"); step(1,0,0,0,"R4"); end
            default: begin repeat (3) step(0,0,0,0,"R1"); step(1,1,0,0,"R4");
                           step(1,0,0,0,"R4"); step(0,0,0,1,"R6"); end
        endcase
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check(2'b10, "R1");

        // R2: request without permission, then long idle: never sleeps.
        step(0,1,0,0,"R2");
        repeat (5) step(0,0,0,0,"R2");
        check(2'b10, "R2");

        // R3: armed while busy stays clocked.
        step(1,1,1,0,"R3");
        repeat (6) step(1,0,1,0,"R3");
        check(2'b10, "R3");
        // R4: busy drops; idle at edges 1,2 counted, sleep at edge 3.
        step(1,0,0,0,"R4"); check(2'b10, "R4");
        step(1,0,1,0,"R4"); check(2'b10, "R4");   // restart count
        step(1,0,0,0,"R4"); step(1,0,0,0,"R4"); check(2'b10, "R4");
        step(1,0,0,0,"R4"); check(2'b01, "R4");
        // R5: inputs toggle while asleep.
        step(0,1,1,0,"R5"); step(1,1,0,0,"R5"); step(0,0,1,0,"R5");
        check(2'b01, "R5");
        // R6: wake ordering.
        step(1,0,0,1,"R6"); check(2'b11, "R6");
        step(1,0,0,0,"R6"); check(2'b10, "R6");

        // R8: mode cleared while armed.
        do_reset();
        step(1,1,1,0,"R8"); step(0,0,0,0,"R8");
        repeat (4) step(1,0,0,0,"R8");
        check(2'b10, "R8");

        // R7: wake at the same edge idle completes.
        reach(2);
        step(1,0,0,1,"R7"); check(2'b10, "R7");
        repeat (3) step(1,0,0,0,"R7");
        check(2'b10, "R7");

        // Exhaustive one-cycle sweep from every starting state.
        for (int s = 0; s < 5; s++) begin
            for (int c = 0; c < 16; c++) begin
                reach(s);
                step(c[3], c[2], c[1], c[0], "R9");
                step(c[3], 0, c[1], 0, "R9");
                step(0, 0, 0, 0, "R9");
            end
        end

        // Pseudo-random run with biased inputs.
        begin
            logic [15:0] lf = 16'hACE1;
            do_reset();
            for (int i = 0; i < 4000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] | lf[1], lf[2] & lf[3], lf[4] & lf[5],
                     lf[6] & lf[7] & lf[8], "R9");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule